// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration register file of a dual-channel disk interface controller. The host reaches it through two byte-wide I/O ports. A write to the base port loads an 8-bit index. The data port, four addresses above the base, then reads or writes the byte that the index selects. The index stays loaded, so the host can make several data accesses in a row to the same register without writing the index again.

The map is sparse. A read-only identity and status byte sits at index 0x50. Writable control, command-timing, per-drive address-setup, per-drive read/write-timing and burst bytes follow at 0x51 to 0x59. A scratch byte at 0x5B lets software confirm that the port is present. A strap input chooses which of two base addresses the decoder answers on, 0x078 or 0x178. The block also exports the decoded fields continuously to the drive-side timing logic: setup codes, active and recovery nibbles, read-ahead disables, secondary-channel enable, fast device-select, command timing and burst size. Drives 2 and 3 share one setup byte and one timing byte.

Read data is registered. `io_rdata` takes its new value on the clock edge that samples the read strobe and keeps that value until the next read.

Top module: `idxcfg_port`

## Requirements
- R1: A write at the base port stores the 8-bit index. A read at the base port returns the index. The index keeps its value until the base port is written again.
- R2: A write at base+4 stores the byte into the register the index selects. A read at base+4 loads that register's value into `io_rdata` on the sampling edge. `io_rdata` does not change in any cycle without a read strobe.
- R3: When `strap_low_base`=1 the base is 0x078; when it is 0 the base is 0x178. Accesses to any other address change no register and no index.
- R4: Index 0x50 reads {`drv_stat`[1:0], `strap_low_base`, DEV_ID[1:0], `irq_stat`, REV[1:0]}, from bit 7 down to bit 0. REV is nonzero. Writes to index 0x50 have no effect.
- R5: The scratch byte at 0x5B reads back any written byte unchanged, for example 0xBD.
- R6: After reset the index is 0x00 and `io_rdata` is 0x00. Registers 0x51 to 0x58 and 0x5B are 0x00, and the burst register 0x59 is 0x40.
- R7: Indices outside 0x50 to 0x59 and 0x5B read 0xFF. Writes to those indices change no register.
- R8: Control byte 0x51: bit 6 gives `ra_dis`[0], bit 7 gives `ra_dis`[1], and bit 3 gives `sec_en`. `fast_sel` is 1 only when bits 0, 1, 2 and 5 are all 1.
- R9: Bits 7:6 of 0x53, 0x55 and 0x57 are the setup codes of drive 0, drive 1, and drives 2 and 3. They appear in `drv_setup` at 2 bits per drive, with drive 0 in the lowest bits. Bits 2 and 3 of 0x57 give `ra_dis`[2] and `ra_dis`[3].
- R10: In timing bytes 0x54 (drive 0), 0x56 (drive 1) and 0x58 (drives 2 and 3), the upper nibble is the active count and the lower nibble is the recovery count. They appear in `drv_active` and `drv_recovery` at 4 bits per drive, with drive 0 lowest. `cmd_tim` exports byte 0x52 and `burst` exports byte 0x59.
- R11: Each of the writable bytes 0x51 to 0x59 keeps all eight written bits and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| strap_low_base | input | 1 | 1 selects base 0x078, 0 selects base 0x178 |
| irq_stat | input | 1 | Interrupt status shown in byte 0x50 |
| drv_stat | input | 2 | Drive status bits shown in byte 0x50 |
| drv_setup | output | 8 | Setup codes, 2 bits per drive |
| drv_active | output | 16 | Active counts, 4 bits per drive |
| drv_recovery | output | 16 | Recovery counts, 4 bits per drive |
| ra_dis | output | 4 | Read-ahead disable, 1 bit per drive |
| sec_en | output | 1 | Secondary channel enable |
| fast_sel | output | 1 | Fast device-select timing |
| cmd_tim | output | 8 | Command timing byte |
| burst | output | 8 | Burst size byte |

## Verification
The bench targets the following corner cases and the failure each one would reveal:

- Writes to the read-only status byte. A decoder that let them through would corrupt the revision or base-flag bits.
- Indices just outside the map (0x4F, 0x5A) and far from it. A loose decoder would alias these onto a neighbouring register, or read them as zero instead of 0xFF.
- The strap choosing the other base. An access at the now-inactive base would then modify state, and status bit 5 would stop following the strap.
- The fast device-select combination with one bit missing. A design that ORed the four bits instead of requiring all of them would report fast timing here.
- The shared drive 2/3 bytes. Swapped fields or nibbles would show up in the wrong drive slot.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;
  localparam int REG_W = 8;
  localparam int NSLOT = 10;

  localparam logic [REG_W-1:0] IDX_STATUS  = 8'h50;
  localparam logic [REG_W-1:0] IDX_FIRST   = 8'h51;
  localparam logic [REG_W-1:0] IDX_BURST   = 8'h59;
  localparam logic [REG_W-1:0] IDX_SCRATCH = 8'h5B;
  localparam logic [REG_W-1:0] BURST_RST   = 8'h40;

  // slot positions of the writable bytes
  localparam int SLOT_CTRL  = 0;
  localparam int SLOT_CMDT  = 1;
  localparam int SLOT_SU0   = 2;
  localparam int SLOT_RW0   = 3;
  localparam int SLOT_SU1   = 4;
  localparam int SLOT_RW1   = 5;
  localparam int SLOT_SU23  = 6;
  localparam int SLOT_RW23  = 7;
  localparam int SLOT_BURST = 8;

  typedef enum logic [1:0] {
    PORT_NONE  = 2'd0,
    PORT_INDEX = 2'd1,
    PORT_DATA  = 2'd2
  } port_sel_e;

  function automatic logic [REG_W-1:0] slot_idx(input int s);
    if (s < NSLOT - 1) return IDX_FIRST + REG_W'(s);
    return IDX_SCRATCH;
  endfunction

  function automatic logic [REG_W-1:0] slot_rst(input int s);
    return (slot_idx(s) == IDX_BURST) ? BURST_RST : '0;
  endfunction
endpackage

// File: rtl/idxcfg_rst_sync.sv
module idxcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/idxcfg_decode.sv
module idxcfg_decode
  import idxcfg_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] BASE_LO = ADDR_W'('h078),
  parameter logic [ADDR_W-1:0] BASE_HI = ADDR_W'('h178),
  parameter int              DATA_OFS = 4
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              strap_low_base,
  output port_sel_e         port_sel
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base = strap_low_base ? BASE_LO : BASE_HI;
    if (io_addr == base)                           port_sel = PORT_INDEX;
    else if (io_addr == base + ADDR_W'(DATA_OFS))  port_sel = PORT_DATA;
    else                                           port_sel = PORT_NONE;
  end
endmodule

// File: rtl/idxcfg_regbank.sv
module idxcfg_regbank
  import idxcfg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        idx_we,
  input  logic                        dat_we,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            idx_q,
  output logic [NSLOT-1:0][REG_W-1:0] regs
);
  logic [REG_W-1:0] idx_d;

  always_comb idx_d = idx_we ? wdata : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [REG_W-1:0] MY_IDX = slot_idx(s);
    localparam logic [REG_W-1:0] MY_RST = slot_rst(s);
    logic             slot_en;
    logic [REG_W-1:0] slot_d;
    logic [REG_W-1:0] slot_q;

    always_comb begin
      slot_en = dat_we && (idx_q == MY_IDX);
      slot_d  = slot_en ? wdata : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= MY_RST;
      else        slot_q <= slot_d;
    end

    assign regs[s] = slot_q;
  end
endmodule

// File: rtl/idxcfg_rdmux.sv
module idxcfg_rdmux
  import idxcfg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_idx,
  input  logic                        rd_dat,
  input  logic [REG_W-1:0]            idx_q,
  input  logic [NSLOT-1:0][REG_W-1:0] regs,
  input  logic [REG_W-1:0]            status_byte,
  output logic [REG_W-1:0]            rdata_q
);
  logic [REG_W-1:0] sel_byte;
  logic [REG_W-1:0] rdata_d;

  always_comb begin
    sel_byte = '1;
    if (idx_q == IDX_STATUS) sel_byte = status_byte;
    for (int s = 0; s < NSLOT; s++) begin
      if (idx_q == slot_idx(s)) sel_byte = regs[s];
    end
  end

  always_comb begin
    if (rd_dat)      rdata_d = sel_byte;
    else if (rd_idx) rdata_d = idx_q;
    else             rdata_d = rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
  import idxcfg_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter logic [1:0] REV    = 2'd2,
  parameter logic [1:0] DEV_ID = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              strap_low_base,
  input  logic              irq_stat,
  input  logic [1:0]        drv_stat,
  output logic [7:0]        drv_setup,
  output logic [15:0]       drv_active,
  output logic [15:0]       drv_recovery,
  output logic [3:0]        ra_dis,
  output logic              sec_en,
  output logic              fast_sel,
  output logic [7:0]        cmd_tim,
  output logic [7:0]        burst
);
  logic                        rst_sync_n;
  port_sel_e                   port_sel;
  logic [REG_W-1:0]            cur_idx;
  logic [NSLOT-1:0][REG_W-1:0] regs;
  logic [REG_W-1:0]            status_byte;
  logic                        idx_we, dat_we, rd_idx, rd_dat;

  idxcfg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  idxcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .io_addr        (io_addr),
    .strap_low_base (strap_low_base),
    .port_sel       (port_sel)
  );

  always_comb begin
    idx_we = io_wr && (port_sel == PORT_INDEX);
    dat_we = io_wr && (port_sel == PORT_DATA);
    rd_idx = io_rd && (port_sel == PORT_INDEX);
    rd_dat = io_rd && (port_sel == PORT_DATA);
    status_byte = {drv_stat, strap_low_base, DEV_ID, irq_stat, REV};
  end

  idxcfg_regbank u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idx_we (idx_we),
    .dat_we (dat_we),
    .wdata  (io_wdata),
    .idx_q  (cur_idx),
    .regs   (regs)
  );

  idxcfg_rdmux u_rd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_idx      (rd_idx),
    .rd_dat      (rd_dat),
    .idx_q       (cur_idx),
    .regs        (regs),
    .status_byte (status_byte),
    .rdata_q     (io_rdata)
  );

  // exported fields; drives 2 and 3 share one setup and one timing byte
  always_comb begin
    drv_setup    = {regs[SLOT_SU23][7:6], regs[SLOT_SU23][7:6],
                    regs[SLOT_SU1][7:6],  regs[SLOT_SU0][7:6]};
    drv_active   = {regs[SLOT_RW23][7:4], regs[SLOT_RW23][7:4],
                    regs[SLOT_RW1][7:4],  regs[SLOT_RW0][7:4]};
    drv_recovery = {regs[SLOT_RW23][3:0], regs[SLOT_RW23][3:0],
                    regs[SLOT_RW1][3:0],  regs[SLOT_RW0][3:0]};
    ra_dis       = {regs[SLOT_SU23][3], regs[SLOT_SU23][2],
                    regs[SLOT_CTRL][7], regs[SLOT_CTRL][6]};
    sec_en       = regs[SLOT_CTRL][3];
    fast_sel     = &{regs[SLOT_CTRL][5], regs[SLOT_CTRL][2:0]};
    cmd_tim      = regs[SLOT_CMDT];
    burst        = regs[SLOT_BURST];
  end
endmodule

// File: rtl/idxcfg_chk.sv
module idxcfg_chk #(
  parameter int         ADDR_W = 10,
  parameter logic [1:0] REV    = 2'd2,
  parameter logic [1:0] DEV_ID = 2'd1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              strap_low_base,
  input logic              irq_stat,
  input logic [1:0]        drv_stat,
  input logic [7:0]        cur_idx,
  input logic              sec_en
);
  logic [ADDR_W-1:0] base;
  logic at_idx, at_dat, known;

  always_comb begin
    base   = strap_low_base ? ADDR_W'('h078) : ADDR_W'('h178);
    at_idx = io_addr == base;
    at_dat = io_addr == base + ADDR_W'(4);
    known  = (cur_idx >= 8'h50 && cur_idx <= 8'h59) || cur_idx == 8'h5B;
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_idx) |=> cur_idx == $past(io_wdata));

  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_idx) |=> $stable(cur_idx));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  // R4
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && cur_idx == 8'h50) |=>
      io_rdata == $past({drv_stat, strap_low_base, DEV_ID, irq_stat, REV}));

  // R7
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && !known) |=> io_rdata == 8'hFF);

  // R8
  sec_en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_dat && cur_idx == 8'h51) |=> $stable(sec_en));
endmodule

bind idxcfg_port idxcfg_chk #(.ADDR_W(ADDR_W), .REV(REV), .DEV_ID(DEV_ID)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .io_addr        (io_addr),
  .io_wr          (io_wr),
  .io_rd          (io_rd),
  .io_wdata       (io_wdata),
  .io_rdata       (io_rdata),
  .strap_low_base (strap_low_base),
  .irq_stat       (irq_stat),
  .drv_stat       (drv_stat),
  .cur_idx        (cur_idx),
  .sec_en         (sec_en)
);

// File: tb/idxcfg_port_bench.sv
module idxcfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic        strap_low_base, irq_stat;
  logic [1:0]  drv_stat;
  logic [7:0]  drv_setup, cmd_tim, burst;
  logic [15:0] drv_active, drv_recovery;
  logic [3:0]  ra_dis;
  logic        sec_en, fast_sel;

  int checks = 0;
  int errors = 0;
  logic [9:0] base;

  always #5 clk = ~clk;

  idxcfg_port u_idxcfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .strap_low_base(strap_low_base),
    .irq_stat(irq_stat), .drv_stat(drv_stat), .drv_setup(drv_setup),
    .drv_active(drv_active), .drv_recovery(drv_recovery), .ra_dis(ra_dis),
    .sec_en(sec_en), .fast_sel(fast_sel), .cmd_tim(cmd_tim), .burst(burst)
  );

  // {index, write byte, expected readback}
  localparam logic [23:0] VEC [13] = '{
    24'h51A5A5, 24'h523C3C, 24'h53C3C3, 24'h549A9A, 24'h558181,
    24'h565E5E, 24'h57F0F0, 24'h580F0F, 24'h592020, 24'h5BBDBD,
    24'h5000AE, 24'h5A12FF, 24'h4F34FF
  };

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    bus_write(base, idx);
    bus_write(base + 10'd4, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] v);
    bus_write(base, idx);
    bus_read(base + 10'd4, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    strap_low_base = 1'b1; irq_stat = 1'b1; drv_stat = 2'b10; base = 10'h078;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    check("R6 rdata reset", io_rdata, 8'h00);
    check("R6 burst out", burst, 8'h40);
    check("R6 fast_sel/sec_en", {fast_sel, sec_en}, 2'b00);
    bus_read(base, v);           check("R6 index reset", v, 8'h00);
    reg_read(8'h51, v);          check("R6 ctrl reset", v, 8'h00);
    reg_read(8'h58, v);          check("R6 rw23 reset", v, 8'h00);
    reg_read(8'h59, v);          check("R6 burst reset", v, 8'h40);
    reg_read(8'h5B, v);          check("R6 scratch reset", v, 8'h00);

    // R11 R5 R4 R7 vector walk
    for (int i = 0; i < 13; i++) begin
      reg_write(VEC[i][23:16], VEC[i][15:8]);
      reg_read(VEC[i][23:16], v);
      check($sformatf("R11/R5/R4/R7 vector idx=%h", VEC[i][23:16]), v, VEC[i][7:0]);
    end

    // R7 writes to holes leave neighbours intact
    reg_write(8'h5A, 8'h55);
    reg_read(8'h5B, v);          check("R7 hole write scratch", v, 8'hBD);
    reg_read(8'h59, v);          check("R7 hole write burst", v, 8'h20);
    reg_read(8'h00, v);          check("R7 far index", v, 8'hFF);

    // R4 status byte unchanged by writes
    reg_write(8'h50, 8'hFF);
    reg_read(8'h50, v);          check("R4 status after write", v, 8'hAE);

    // R8 control decoding
    reg_write(8'h51, 8'h27);
    check("R8 fast_sel on", {fast_sel, sec_en, ra_dis[1:0]}, 4'b1000);
    reg_write(8'h51, 8'h26);
    check("R8 fast_sel missing bit0", fast_sel, 1'b0);
    reg_write(8'h51, 8'hC8);
    check("R8 ra_dis/sec_en", {fast_sel, sec_en, ra_dis[1:0]}, 4'b0111);

    // R9 setup fields
    reg_write(8'h57, 8'h8C);
    reg_write(8'h53, 8'h40);
    reg_write(8'h55, 8'hC0);
    check("R9 ra_dis drives 2,3", ra_dis[3:2], 2'b11);
    check("R9 setup codes", drv_setup, 8'b10_10_11_01);

    // R10 timing fields
    reg_write(8'h54, 8'h9A);
    reg_write(8'h56, 8'h21);
    reg_write(8'h58, 8'h3F);
    reg_write(8'h52, 8'h77);
    reg_write(8'h59, 8'h40);
    check("R10 active", drv_active, 16'h3329);
    check("R10 recovery", drv_recovery, 16'hFF1A);
    check("R10 cmd_tim/burst", {cmd_tim, burst}, 16'h7740);

    // R1 index hold and back-to-back data reads
    bus_write(base, 8'h5B);
    bus_read(base + 10'd4, v);
    bus_read(base + 10'd4, v2);
    check("R1 back-to-back", {v, v2}, 16'hBDBD);
    bus_read(base, v);           check("R1 index readback", v, 8'h5B);

    // R2 rdata holds without a read
    bus_write(base + 10'd4, 8'h11);
    check("R2 rdata hold", io_rdata, 8'h5B);
    reg_read(8'h5B, v);          check("R2 data write", v, 8'h11);

    // R3 other base
    strap_low_base = 1'b0;
    bus_write(10'h078, 8'h52);
    bus_write(10'h07C, 8'h00);
    base = 10'h178;
    bus_read(base, v);           check("R3 old base no index", v, 8'h5B);
    reg_read(8'h52, v);          check("R3 old base no data", v, 8'h77);
    reg_read(8'h50, v);          check("R3 status strap bit", v, 8'h8E);
    bus_write(10'h17D, 8'h51);
    bus_read(base, v);           check("R3 near address ignored", v, 8'h50);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule